// File: doc/BRIEF.md
# I2C Prioritized Interrupt Vector Unit

This block sits beside an I2C bus engine and turns its single-cycle event strobes into software-visible interrupt state. The block recognizes seven kinds of event: arbitration lost, no-acknowledge, access ready, receive ready, transmit ready, stop detected and addressed-as-slave. Each strobe sets a sticky flag in a status register. An enable mask selects which flags may raise the level interrupt output. The same mask selects which flags the vector register may report.

Software services the interrupt by reading the vector register. Each read returns the code of the highest-priority pending enabled event and clears that event's flag in the same access, so repeated reads walk the pending set down to zero. Flags can also be cleared one at a time by writing ones to the status register. The status register additionally shows two live levels from the engine: bus busy and receive shift register full.

Top module: `i2c_irq_vector_unit`

## Requirements
- R1: A strobe on any event input sets its status flag on the next clock whatever the mask. Flag positions: arbitration lost bit 0, no-acknowledge bit 1, access ready bit 2, receive ready bit 3, transmit ready bit 4, stop detected bit 5, addressed-as-slave bit 6.
- R2: The status register (offset 0x08) shows the bus-busy input at bit 12 and the receive-shift-full input at bit 11. These bits are live levels and are not latched.
- R3: Writing the status register clears every flag whose bit in the write data is one. Zero bits and bits above 6 have no effect.
- R4: The mask register (offset 0x04) stores write data bits 6:0, at the same positions as the status flags. It reads back with bits 15:7 as zero.
- R5: The vector register (offset 0x28) reads as the code of the selected event: arbitration lost 1, no-acknowledge 2, access ready 3, receive ready 4, transmit ready 5, stop detected 6, addressed-as-slave 7. It reads 0 when no enabled flag is pending.
- R6: When several enabled flags are pending, the vector reports the lowest code.
- R7: A vector read clears the flag whose code it returns. Repeated reads return the remaining enabled events in priority order and then 0.
- R8: A flag whose mask bit is clear still shows in the status register. The vector register never reports it, and a vector read never clears it.
- R9: The interrupt output is high exactly while some flag is set and has its mask bit set.
- R10: An event strobe in the same cycle as a clear of that flag (status write or vector read) leaves the flag set.
- R11: After synchronous reset, all flags, the mask and the read data are zero, and the interrupt output is low.
- R12: Read data appears on the clock after the read strobe. Reads of any other offset return 0. In cycles without a read strobe the read data is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_arb_lost | input | 1 | Arbitration-lost strobe |
| ev_nack | input | 1 | No-acknowledge strobe |
| ev_acc_rdy | input | 1 | Access-ready strobe |
| ev_rx_rdy | input | 1 | Receive-ready strobe |
| ev_tx_rdy | input | 1 | Transmit-ready strobe |
| ev_stop | input | 1 | Stop-detected strobe |
| ev_as_slave | input | 1 | Addressed-as-slave strobe |
| bus_busy | input | 1 | Bus busy level |
| rx_shift_full | input | 1 | Receive shift register full level |
| reg_addr | input | 8 | Register byte offset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data, one cycle after the read |
| irq | output | 1 | Level interrupt request |

## Verification
The hardest case to reach is a clear that meets a new strobe for the same flag in the same cycle. This matters most for a vector read, where the flag being cleared is chosen by the priority logic in that cycle. The bench reaches it by narrowing the mask to a single event, so the outcome of the read is known in advance, and then issuing the read together with that event's strobe. A long random phase then mixes strobes, writes and reads of all offsets against a cycle-accurate model.

// File: rtl/i2c_irqv_pkg.sv
package i2c_irqv_pkg;

    localparam int NUM_EVT = 7;
    localparam int DATA_W  = 16;
    localparam int ADDR_W  = 8;
    localparam int CODE_W  = $clog2(NUM_EVT + 1);

    localparam logic [ADDR_W-1:0] OFS_MASK   = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_STATUS = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_VECTOR = 8'h28;

    localparam int BUSY_BIT = 12;
    localparam int RSF_BIT  = 11;

    typedef enum logic [CODE_W-1:0] {
        VEC_NONE     = 3'd0,
        VEC_ARB_LOST = 3'd1,
        VEC_NACK     = 3'd2,
        VEC_ACC_RDY  = 3'd3,
        VEC_RX_RDY   = 3'd4,
        VEC_TX_RDY   = 3'd5,
        VEC_STOP     = 3'd6,
        VEC_AS_SLAVE = 3'd7
    } vec_code_e;

    typedef struct packed {
        logic              wr;
        logic              rd;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } reg_req_t;

    // Lowest set bit wins; code is bit index plus one, zero when none.
    function automatic logic [CODE_W-1:0] pick_code(input logic [NUM_EVT-1:0] pend);
        logic [CODE_W-1:0] r;
        r = '0;
        for (int i = NUM_EVT - 1; i >= 0; i--) begin
            if (pend[i]) r = CODE_W'(i + 1);
        end
        return r;
    endfunction

endpackage

// File: rtl/i2c_irqv_flags.sv
module i2c_irqv_flags
    import i2c_irqv_pkg::*;
#(
    parameter int N = NUM_EVT
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] flag_o
);

    for (genvar i = 0; i < N; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)           flag_o[i] <= 1'b0;
            else if (set_i[i]) flag_o[i] <= 1'b1;
            else if (clr_i[i]) flag_o[i] <= 1'b0;
        end

        AST_EVENT_SETS: assert property (@(posedge clk) disable iff (rst)
            set_i[i] |=> flag_o[i]);  // R10
        AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (rst)
            (clr_i[i] && !set_i[i]) |=> !flag_o[i]);  // R3
        AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (rst)
            (!clr_i[i] && !set_i[i]) |=> flag_o[i] == $past(flag_o[i]));  // R1
    end

endmodule

// File: rtl/i2c_irqv_prio.sv
module i2c_irqv_prio
    import i2c_irqv_pkg::*;
#(
    parameter int N  = NUM_EVT,
    parameter int CW = CODE_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [N-1:0]  flags_i,
    input  logic [N-1:0]  mask_i,
    output logic [CW-1:0] code_o,
    output logic          any_o
);

    logic [N-1:0] pend;

    always_comb begin
        pend   = flags_i & mask_i;
        any_o  = |pend;
        code_o = pick_code(pend);
    end

    AST_CODE_IS_PENDING: assert property (@(posedge clk) disable iff (rst)
        (code_o != '0) |-> pend[code_o - 1'b1]);  // R5
    AST_CODE_LOWEST: assert property (@(posedge clk) disable iff (rst)
        (code_o != '0) |-> (pend & ~({N{1'b1}} << (code_o - 1'b1))) == '0);  // R6
    AST_MASKED_SILENT: assert property (@(posedge clk) disable iff (rst)
        ((flags_i & mask_i) == '0) |-> code_o == '0);  // R8

endmodule

// File: rtl/i2c_irqv_regs.sv
module i2c_irqv_regs
    import i2c_irqv_pkg::*;
#(
    parameter int N  = NUM_EVT,
    parameter int DW = DATA_W,
    parameter int CW = CODE_W
) (
    input  logic          clk,
    input  logic          rst,
    input  reg_req_t      req_i,
    input  logic [N-1:0]  flags_i,
    input  logic [CW-1:0] code_i,
    input  logic          busy_i,
    input  logic          rsf_i,
    output logic [N-1:0]  mask_o,
    output logic [N-1:0]  clr_o,
    output logic [DW-1:0] rdata_o
);

    logic          hit_mask, hit_status, hit_vector;
    logic [N-1:0]  vec_clr;
    logic [N-1:0]  w1c_clr;
    logic [DW-1:0] status_word;
    logic [DW-1:0] rd_next;

    assign hit_mask   = req_i.addr == OFS_MASK;
    assign hit_status = req_i.addr == OFS_STATUS;
    assign hit_vector = req_i.addr == OFS_VECTOR;

    for (genvar i = 0; i < N; i++) begin : g_vclr
        assign vec_clr[i] = req_i.rd && hit_vector && (code_i == CW'(i + 1));
    end

    assign w1c_clr = (req_i.wr && hit_status) ? req_i.wdata[N-1:0] : '0;
    assign clr_o   = vec_clr | w1c_clr;

    always_comb begin
        status_word            = '0;
        status_word[N-1:0]     = flags_i;
        status_word[BUSY_BIT]  = busy_i;
        status_word[RSF_BIT]   = rsf_i;
    end

    always_comb begin
        rd_next = '0;
        if (req_i.rd) begin
            if (hit_mask)        rd_next = DW'(mask_o);
            else if (hit_status) rd_next = status_word;
            else if (hit_vector) rd_next = DW'(code_i);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_o  <= '0;
            rdata_o <= '0;
        end else begin
            rdata_o <= rd_next;
            if (req_i.wr && hit_mask) mask_o <= req_i.wdata[N-1:0];
        end
    end

    AST_MASK_WRITE: assert property (@(posedge clk) disable iff (rst)
        (req_i.wr && hit_mask) |=> mask_o == $past(req_i.wdata[N-1:0]));  // R4
    AST_IDLE_RDATA: assert property (@(posedge clk) disable iff (rst)
        !req_i.rd |=> rdata_o == '0);  // R12
    AST_VEC_ONE_CLEAR: assert property (@(posedge clk) disable iff (rst)
        $countones(vec_clr) <= 1);  // R7

endmodule

// File: rtl/i2c_irq_vector_unit.sv
module i2c_irq_vector_unit
    import i2c_irqv_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ev_arb_lost,
    input  logic              ev_nack,
    input  logic              ev_acc_rdy,
    input  logic              ev_rx_rdy,
    input  logic              ev_tx_rdy,
    input  logic              ev_stop,
    input  logic              ev_as_slave,
    input  logic              bus_busy,
    input  logic              rx_shift_full,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq
);

    logic [NUM_EVT-1:0] ev_vec;
    logic [NUM_EVT-1:0] flags;
    logic [NUM_EVT-1:0] mask;
    logic [NUM_EVT-1:0] clr;
    logic [CODE_W-1:0]  code;
    logic               any_pend;
    reg_req_t           req;

    assign ev_vec = {ev_as_slave, ev_stop, ev_tx_rdy, ev_rx_rdy,
                     ev_acc_rdy, ev_nack, ev_arb_lost};

    assign req = '{wr: reg_wr, rd: reg_rd, addr: reg_addr, wdata: reg_wdata};

    i2c_irqv_flags #(.N(NUM_EVT)) u_flags (
        .clk    (clk),
        .rst    (rst),
        .set_i  (ev_vec),
        .clr_i  (clr),
        .flag_o (flags)
    );

    i2c_irqv_prio #(.N(NUM_EVT), .CW(CODE_W)) u_prio (
        .clk     (clk),
        .rst     (rst),
        .flags_i (flags),
        .mask_i  (mask),
        .code_o  (code),
        .any_o   (any_pend)
    );

    i2c_irqv_regs #(.N(NUM_EVT), .DW(DATA_W), .CW(CODE_W)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .req_i   (req),
        .flags_i (flags),
        .code_i  (code),
        .busy_i  (bus_busy),
        .rsf_i   (rx_shift_full),
        .mask_o  (mask),
        .clr_o   (clr),
        .rdata_o (reg_rdata)
    );

    assign irq = any_pend;

    AST_IRQ_HAS_VECTOR: assert property (@(posedge clk) disable iff (rst)
        irq |-> code != '0);  // R9
    AST_VEC_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (reg_rd && reg_addr == OFS_VECTOR && code != '0 && !ev_vec[code - 1'b1])
        |=> !flags[$past(code) - 1'b1]);  // R7

endmodule

// File: tb/sim_i2c_irq_vector_unit.sv
module sim_i2c_irq_vector_unit;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [6:0]  ev = '0;
    logic        bus_busy = 1'b0;
    logic        rx_shift_full = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        irq;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;
    string cur_req = "R11";

    always #2.5 clk = ~clk;

    i2c_irq_vector_unit u0 (
        .clk(clk), .rst(rst),
        .ev_arb_lost(ev[0]), .ev_nack(ev[1]), .ev_acc_rdy(ev[2]),
        .ev_rx_rdy(ev[3]), .ev_tx_rdy(ev[4]), .ev_stop(ev[5]),
        .ev_as_slave(ev[6]),
        .bus_busy(bus_busy), .rx_shift_full(rx_shift_full),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    // Behavioural reference model
    logic [6:0]  m_flags = '0;
    logic [6:0]  m_mask  = '0;
    logic [15:0] m_rdata = '0;

    always @(posedge clk) begin
        logic [6:0]  pend;
        logic [6:0]  clrv;
        logic [15:0] nrd;
        int code;
        if (rst) begin
            m_flags = '0; m_mask = '0; m_rdata = '0;
        end else begin
            pend = m_flags & m_mask;
            code = 0;
            for (int i = 0; i < 7; i++) if (code == 0 && pend[i]) code = i + 1;
            clrv = '0;
            nrd  = '0;
            if (reg_rd) begin
                if (reg_addr == 8'h04) nrd = {9'd0, m_mask};
                else if (reg_addr == 8'h08)
                    nrd = {3'd0, bus_busy, rx_shift_full, 4'd0, m_flags};
                else if (reg_addr == 8'h28) begin
                    nrd = 16'(code);
                    if (code != 0) clrv[code-1] = 1'b1;
                end
            end
            if (reg_wr && reg_addr == 8'h08) clrv = clrv | reg_wdata[6:0];
            if (reg_wr && reg_addr == 8'h04) m_mask = reg_wdata[6:0];
            m_flags = (m_flags & ~clrv) | ev;
            m_rdata = nrd;
        end
    end

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    // Per-cycle compare against the model, away from the active edge
    always @(negedge clk) begin
        if (!rst && !done) begin
            chk({cur_req, "/R12 rdata"}, reg_rdata, m_rdata);
            chk("R9 irq", {15'd0, irq}, {15'd0, (m_flags & m_mask) != 0});
        end
    end

    task automatic bus(input logic r, input logic w, input logic [7:0] a,
                       input logic [15:0] d, input logic [6:0] e,
                       output logic [15:0] q);
        @(negedge clk);
        reg_rd = r; reg_wr = w; reg_addr = a; reg_wdata = d; ev = e;
        @(negedge clk);
        reg_rd = 1'b0; reg_wr = 1'b0; ev = '0;
        #0.1 q = reg_rdata;
    endtask

    logic [15:0] q;

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R11: reset state
        cur_req = "R11";
        chk("R11 irq", {15'd0, irq}, 16'd0);
        bus(1, 0, 8'h08, 0, 0, q); chk("R11 status", q, 16'h0000);
        bus(1, 0, 8'h04, 0, 0, q); chk("R11 mask", q, 16'h0000);
        bus(1, 0, 8'h28, 0, 0, q); chk("R11 vector", q, 16'h0000);

        // R1 / R8: events latch with mask clear; vector silent
        cur_req = "R1";
        bus(0, 0, 0, 0, 7'h7F, q);
        bus(1, 0, 8'h08, 0, 0, q); chk("R1 all flags", q, 16'h007F);
        chk("R9 masked irq low", {15'd0, irq}, 16'd0);
        cur_req = "R8";
        bus(1, 0, 8'h28, 0, 0, q); chk("R8 vector masked", q, 16'h0000);
        bus(1, 0, 8'h08, 0, 0, q); chk("R8 flags kept", q, 16'h007F);

        // R4: mask readback
        cur_req = "R4";
        bus(0, 1, 8'h04, 16'hFFFF, 0, q);
        bus(1, 0, 8'h04, 0, 0, q); chk("R4 mask readback", q, 16'h007F);
        chk("R9 irq high", {15'd0, irq}, 16'd1);

        // R5 / R6 / R7: walk vector
        cur_req = "R7";
        for (int k = 1; k <= 7; k++) begin
            bus(1, 0, 8'h28, 0, 0, q); chk("R5/R6/R7 vector order", q, 16'(k));
        end
        bus(1, 0, 8'h28, 0, 0, q); chk("R7 vector drained", q, 16'h0000);
        chk("R9 irq low after drain", {15'd0, irq}, 16'd0);

        // R2: live levels
        cur_req = "R2";
        bus_busy = 1'b1; rx_shift_full = 1'b0;
        bus(1, 0, 8'h08, 0, 0, q); chk("R2 busy", q, 16'h1000);
        bus_busy = 1'b0; rx_shift_full = 1'b1;
        bus(1, 0, 8'h08, 0, 0, q); chk("R2 rsf", q, 16'h0800);
        rx_shift_full = 1'b0;

        // R3: write-one-to-clear
        cur_req = "R3";
        bus(0, 0, 0, 0, 7'b0101001, q);
        bus(0, 1, 8'h08, 16'hFF89, 0, q);
        bus(1, 0, 8'h08, 0, 0, q); chk("R3 w1c", q, 16'h0020);
        bus(0, 1, 8'h08, 16'h0000, 0, q);
        bus(1, 0, 8'h08, 0, 0, q); chk("R3 zero write", q, 16'h0020);

        // R10: clear colliding with strobe
        cur_req = "R10";
        bus(0, 1, 8'h08, 16'h0020, 7'h20, q);
        bus(1, 0, 8'h08, 0, 0, q); chk("R10 w1c collide", q, 16'h0020);
        bus(0, 1, 8'h04, 16'h0020, 0, q);
        bus(1, 0, 8'h28, 0, 7'h20, q); chk("R10 vec read code", q, 16'h0006);
        bus(1, 0, 8'h28, 0, 0, q); chk("R10 vec collide kept", q, 16'h0006);
        bus(1, 0, 8'h28, 0, 0, q); chk("R10 then cleared", q, 16'h0000);

        // R8: partial mask
        cur_req = "R8";
        bus(0, 1, 8'h04, 16'h0004, 0, q);
        bus(0, 0, 0, 0, 7'b0000111, q);
        bus(1, 0, 8'h28, 0, 0, q); chk("R8 only enabled", q, 16'h0003);
        bus(1, 0, 8'h28, 0, 0, q); chk("R8 masked not reported", q, 16'h0000);
        bus(1, 0, 8'h08, 0, 0, q); chk("R8 masked kept", q, 16'h0003);

        // R12: unmapped offset
        cur_req = "R12";
        bus(1, 0, 8'h10, 0, 0, q); chk("R12 unmapped", q, 16'h0000);

        // Random mix against the model
        cur_req = "R1/R3/R7 random";
        for (int n = 0; n < 2000; n++) begin
            int op;
            logic [7:0] a;
            op = $urandom_range(0, 3);
            case ($urandom_range(0, 3))
                0: a = 8'h04; 1: a = 8'h08; 2: a = 8'h28; default: a = 8'h14;
            endcase
            bus_busy = 1'($urandom);
            rx_shift_full = 1'($urandom);
            bus(op == 1, op == 2, a, 16'($urandom),
                ($urandom_range(0, 2) == 0) ? 7'($urandom) : 7'd0, q);
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

endmodule